// File: doc/BRIEF.md
# Mode-Gated Selectable-Clock Capture Timer

This block is an 8-bit up-counter. Its count rate comes from one of four sources: three taps of a free-running prescaler on the system clock, and a divide-by-4 of a slow watch clock. The counter never runs on the chosen clock directly. The chosen clock's level is sampled every system clock cycle, and the counter steps when that sampled level goes from high to low. A consequence follows from this. If the select is changed while the old source is high and the new one is low, the change looks like a falling edge and the counter steps once.

A 3-bit power-mode input and a 2-bit subclock select decide whether the counter and the capture path may run at all.

A capture input is handled as follows:
- It first passes through a two-stage synchronizer.
- It is then filtered by a 3-sample majority vote, with a new sample taken on each count tick.
- On a filtered rising edge, the count is copied into one capture register.
- On a filtered falling edge, the count is copied into a second capture register.

A synchronous active-low reset does the same as the reset power mode.

Top module: `gated_capture_timer`

## Requirements
- R1: The counter steps by one on each high-to-low change of the sampled level of the selected clock. The clock select codes are:
  - 00: system clock / 64
  - 01: system clock / 32
  - 10: system clock / 2
  - 11: watch clock / 4

  In active mode, E cycles after leaving reset with a system tap of period P selected, the count is floor((E-1)/P) mod 256.
- R2: A select change from a source that is currently high to one that is currently low steps the counter once, in the cycle of the change. A change from low to high does not step it.
- R3: In active or sleep mode with select 11, the watch level passes through a two-stage synchronizer. With a watch period of W system cycles, the count after E cycles is within one of E/(4W).
- R4: The power-mode codes are:
  - 0: reset
  - 1: active
  - 2: sleep
  - 3: watch
  - 4: subactive
  - 5: subsleep
  - 6: standby
  - 7: module standby

  In active and sleep modes any select runs. In watch mode only select 11 runs, and the synchronizer is bypassed. Any other select holds the count.
- R5: In subactive and subsleep modes the timer runs only with select 11 and subclock select 10 (watch / 2). Subclock codes 00 (/8), 01 (/4) and 11 stop it.
- R6: In standby and module standby the count and both capture registers hold their values, whatever the capture input does.
- R7: Reset mode, or rst_n low, clears the count, both capture registers, the overflow strobe, the prescaler and the watch divider.
- R8: The filter only changes after two of its three tick-spaced samples agree. A capture-input pulse one system cycle long never causes a capture.
- R9: A filtered rising edge loads cap_rise, and a filtered falling edge loads cap_fall, with the count value before that tick's increment. Under select 10 in active mode, a level change applied while the count is c gives a captured value of c+2.
- R10: When the mode and selects do not allow running, changes on the capture input cause no capture.
- R11: The counter wraps from 0xFF to 0x00. In the same cycle that it shows 0x00, ovf is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk | input | 1 | Watch clock level, asynchronous to clk |
| mode | input | 3 | Power-mode code |
| clk_sel | input | 2 | Count clock select |
| sub_sel | input | 2 | Subclock select |
| cap_in | input | 1 | Capture input, asynchronous |
| count | output | 8 | Counter value |
| cap_fall | output | 8 | Count captured on filtered falling edge |
| cap_rise | output | 8 | Count captured on filtered rising edge |
| ovf | output | 1 | One-cycle wrap strobe |

## Verification
The spurious step on a select change is the hardest case to reach from the ports. It needs the old source high and the new source low in the same cycle. The stimulus gets there by clearing the prescaler with the reset mode and running exactly 40 cycles under the divide-by-64 tap, so that this tap is high while the divide-by-2 tap is low. It then switches the select at that point, and repeats the opposite case after 11 cycles. Mode gating is swept over every mode, clock select and subclock select, with expected counts computed from the prescaler period. The filter is probed with a capture pulse one system cycle long, sandwiched between real level changes whose capture values are predicted exactly.

// File: rtl/tmr_pkg.sv
// Shared types for the gated capture timer: power modes, clock and subclock
// selects, and the rule that says when counting and capture may proceed.
package tmr_pkg;

    typedef enum logic [2:0] {
        PM_RESET  = 3'd0,
        PM_ACTIVE = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_WATCH  = 3'd3,
        PM_SUBACT = 3'd4,
        PM_SUBSLP = 3'd5,
        PM_STBY   = 3'd6,
        PM_MSTBY  = 3'd7
    } pmode_e;

    typedef enum logic [1:0] {
        CS_SYS64 = 2'd0,
        CS_SYS32 = 2'd1,
        CS_SYS2  = 2'd2,
        CS_WDIV4 = 2'd3
    } csel_e;

    typedef enum logic [1:0] {
        SC_W8   = 2'd0,
        SC_W4   = 2'd1,
        SC_W2   = 2'd2,
        SC_RSVD = 2'd3
    } subsel_e;

    // Decide whether the current mode/select combination lets the timer run.
    function automatic logic run_allowed(pmode_e m, csel_e c, subsel_e s);
        case (m)
            PM_ACTIVE, PM_SLEEP: return 1'b1;
            PM_WATCH:            return (c == CS_WDIV4);
            PM_SUBACT, PM_SUBSLP: return (c == CS_WDIV4) && (s == SC_W2);
            default:             return 1'b0;
        endcase
    endfunction

    // Low-power modes where the system domain is assumed to run from the
    // watch source, so the watch synchronizer is bypassed.
    function automatic logic is_low_power(pmode_e m);
        return (m == PM_WATCH) || (m == PM_SUBACT) || (m == PM_SUBSLP);
    endfunction

endpackage

// File: rtl/tmr_clk_sel.sv
// Count-clock selection. A free-running prescaler supplies three system
// taps; the watch level is synchronized (or taken after one flop in low
// power modes) and divided by 4. The selected level is compared with its
// value one cycle earlier; a high-to-low change gives a one-cycle tick.
// Assumes wclk is much slower than clk. Because the previous level is held
// across a select change, switching from a high source to a low one ticks.
module tmr_clk_sel
    import tmr_pkg::*;
#(
    parameter int PRESC_W     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  lowpow,
    input  csel_e csel,
    input  logic  wclk,
    output logic  tick
);
    localparam int TAP_SLOW = PRESC_W - 1;
    localparam int TAP_MID  = PRESC_W - 2;
    localparam int TAP_FAST = 0;
    localparam int WDIV_W   = 2;

    logic [PRESC_W-1:0]     presc;
    logic [SYNC_STAGES-1:0] wsync;
    logic                   w_lvl;
    logic                   w_prev;
    logic [WDIV_W-1:0]      wdiv;
    logic                   sel_lvl;
    logic                   lvl_prev;

    // Free-running system prescaler, cleared by reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) presc <= '0;
        else               presc <= presc + 1'b1;
    end

    // Shift the watch level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) wsync <= '0;
        else        wsync <= {wsync[SYNC_STAGES-2:0], wclk};
    end

    // Pick the full synchronizer output in fast modes, the first flop otherwise.
    always_comb w_lvl = lowpow ? wsync[0] : wsync[SYNC_STAGES-1];

    // Divide the watch level by 4 by counting its rising changes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            w_prev <= 1'b0;
            wdiv   <= '0;
        end else begin
            w_prev <= w_lvl;
            if (w_lvl && !w_prev) wdiv <= wdiv + 1'b1;
        end
    end

    // Multiplex the selected clock level.
    always_comb begin
        case (csel)
            CS_SYS64: sel_lvl = presc[TAP_SLOW];
            CS_SYS32: sel_lvl = presc[TAP_MID];
            CS_SYS2:  sel_lvl = presc[TAP_FAST];
            default:  sel_lvl = wdiv[WDIV_W-1];
        endcase
    end

    // Remember last cycle's selected level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lvl_prev <= 1'b0;
        else               lvl_prev <= sel_lvl;
    end

    always_comb tick = lvl_prev && !sel_lvl;

    // R1: a tick is always a single-cycle event.
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> !tick);

endmodule

// File: rtl/tmr_counter.sv
// Up-counter with wrap strobe. Steps on inc, clears on clr, otherwise holds.
// The overflow strobe is registered together with the wrap to zero.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count, clear or hold, and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= inc && (cnt == CNT_MAX);
            if (inc) cnt <= cnt + 1'b1;
        end
    end

    // R1: each enabled tick advances the count by exactly one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R6: without a tick the count holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));
    // R7: reset mode leaves zero count and no strobe.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !ovf);
    // R11: the strobe only accompanies a zero count.
    a_r11_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == '0));

endmodule

// File: rtl/tmr_capture.sv
// Capture path: two-stage synchronizer, 3-sample majority filter stepped
// on each enabled count tick, and edge capture of the count into the
// falling-edge and rising-edge registers. The captured value is the count
// before the increment of the same tick. Holds everything when not ticking.
module tmr_capture #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_en,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_fall,
    output logic [CNT_W-1:0] cap_rise
);
    localparam int FILT_N = 3;

    logic [SYNC_STAGES-1:0] csync;
    logic [FILT_N-1:0]      samp;
    logic [FILT_N-1:0]      samp_nx;
    logic                   maj_nx;
    logic                   filt_q;

    // Bring the capture input into the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) csync <= '0;
        else        csync <= {csync[SYNC_STAGES-2:0], cap_in};
    end

    // Next sample window and its majority vote.
    always_comb begin
        samp_nx = {samp[FILT_N-2:0], csync[SYNC_STAGES-1]};
        maj_nx  = (samp_nx[0] & samp_nx[1]) | (samp_nx[0] & samp_nx[2]) |
                  (samp_nx[1] & samp_nx[2]);
    end

    // Step the filter on a tick and capture on a filtered level change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            samp     <= '0;
            filt_q   <= 1'b0;
            cap_fall <= '0;
            cap_rise <= '0;
        end else if (tick_en) begin
            samp   <= samp_nx;
            filt_q <= maj_nx;
            if (filt_q && !maj_nx) cap_fall <= cnt;
            if (!filt_q && maj_nx) cap_rise <= cnt;
        end
    end

    // R6 R10: with no enabled tick both capture registers hold.
    a_r10_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick_en) |=> $stable(cap_fall) && $stable(cap_rise));
    // R8: the filtered level never flips while the filter is idle.
    a_r8_filt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick_en) |=> $stable(filt_q));
    // R7: reset mode zeroes both capture registers.
    a_r7_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cap_fall == '0) && (cap_rise == '0));

endmodule

// File: rtl/gated_capture_timer.sv
// Top level of the mode-gated capture timer. Decodes the power mode and
// selects into a clear and a run permission, and wires the clock selector,
// counter and capture path together. Assumes wclk and cap_in are
// asynchronous levels; all state is in the clk domain.
module gated_capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRESC_W     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    input  logic [2:0]       mode,
    input  logic [1:0]       clk_sel,
    input  logic [1:0]       sub_sel,
    input  logic             cap_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_fall,
    output logic [CNT_W-1:0] cap_rise,
    output logic             ovf
);
    pmode_e  pm;
    csel_e   cs;
    subsel_e ss;
    logic    clr;
    logic    run;
    logic    lowpow;
    logic    tick;
    logic    tick_en;

    // Decode mode and selects into control terms.
    always_comb begin
        pm      = pmode_e'(mode);
        cs      = csel_e'(clk_sel);
        ss      = subsel_e'(sub_sel);
        clr     = (pm == PM_RESET);
        run     = run_allowed(pm, cs, ss);
        lowpow  = is_low_power(pm);
        tick_en = tick && run;
    end

    tmr_clk_sel #(
        .PRESC_W     (PRESC_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) clk_sel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .lowpow (lowpow),
        .csel   (cs),
        .wclk   (wclk),
        .tick   (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (tick_en),
        .cnt   (count),
        .ovf   (ovf)
    );

    tmr_capture #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick_en  (tick_en),
        .cap_in   (cap_in),
        .cnt      (count),
        .cap_fall (cap_fall),
        .cap_rise (cap_rise)
    );

    // R6: standby modes freeze the count.
    a_r6_standby: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd6) || (mode == 3'd7)) |=> $stable(count));
    // R5: subactive with a wrong subclock freezes the count.
    a_r5_subclk: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode == 3'd4) || (mode == 3'd5)) && (sub_sel != 2'd2)) |=> $stable(count));
    // R4: watch mode with a system tap freezes the count.
    a_r4_watch_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd3) && (clk_sel != 2'd3)) |=> $stable(count));

endmodule

// File: tb/gated_capture_timer_tb_top.sv
`timescale 1ns/1ps
module gated_capture_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk = 1'b0;
    logic [2:0] mode = 3'd1;
    logic [1:0] clk_sel = 2'd0;
    logic [1:0] sub_sel = 2'd0;
    logic       cap_in = 1'b0;
    logic [7:0] count, cap_fall, cap_rise;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    localparam int WHALF = 3;   // watch half-period in system cycles

    gated_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .mode(mode),
        .clk_sel(clk_sel), .sub_sel(sub_sel), .cap_in(cap_in),
        .count(count), .cap_fall(cap_fall), .cap_rise(cap_rise), .ovf(ovf)
    );

    always #2 clk = ~clk;

    // Watch clock, toggled away from the active edge.
    int wcnt = 0;
    always @(negedge clk) begin
        wcnt = wcnt + 1;
        if (wcnt == WHALF) begin
            wcnt = 0;
            wclk = ~wclk;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mode_reset();
        mode = 3'd0;
        step(1);
    endtask

    function automatic int tap_period(int s);
        case (s)
            0: return 64;
            1: return 32;
            default: return 2;
        endcase
    endfunction

    function automatic bit runs(int m, int s, int sb);
        if (m == 1 || m == 2) return 1'b1;
        if (m == 3) return s == 3;
        if (m == 4 || m == 5) return (s == 3) && (sb == 2);
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] c0, f0, r0;
        step(3);
        // R7: reset state
        chk(count == 0, "R7 reset count", count, 0);
        chk(cap_fall == 0 && cap_rise == 0, "R7 reset caps", cap_fall, 0);
        chk(ovf == 0, "R7 reset ovf", ovf, 0);
        rst_n = 1'b1;

        // R2: high-to-low select change gives one step
        mode_reset();
        mode = 3'd1; clk_sel = 2'd0;
        step(40);
        chk(count == 0, "R2 pre-switch count", count, 0);
        clk_sel = 2'd2;
        step(1);
        chk(count == 1, "R2 high-to-low step", count, 1);
        // R2: low-to-high change gives none
        mode_reset();
        mode = 3'd1; clk_sel = 2'd0;
        step(11);
        clk_sel = 2'd2;
        step(1);
        chk(count == 0, "R2 low-to-high no step", count, 0);
        step(1);
        chk(count == 1, "R2 next real edge", count, 1);

        // R9: rising capture
        mode_reset();
        mode = 3'd1; clk_sel = 2'd2;
        step(20);
        c0 = count;
        cap_in = 1'b1;
        step(20);
        chk(cap_rise == 8'(c0 + 2), "R9 rise capture", cap_rise, 8'(c0 + 2));
        chk(cap_fall == 0, "R9 no fall capture", cap_fall, 0);
        // R8: one-cycle glitch is filtered
        r0 = cap_rise;
        cap_in = 1'b0;
        step(1);
        cap_in = 1'b1;
        step(20);
        chk(cap_fall == 0, "R8 glitch no fall capture", cap_fall, 0);
        chk(cap_rise == r0, "R8 glitch rise unchanged", cap_rise, r0);
        // R9: falling capture
        c0 = count;
        cap_in = 1'b0;
        step(20);
        chk(cap_fall == 8'(c0 + 2), "R9 fall capture", cap_fall, 8'(c0 + 2));

        // R6: standby holds count and captures
        c0 = count; f0 = cap_fall; r0 = cap_rise;
        mode = 3'd6;
        cap_in = 1'b1;
        step(30);
        chk(count == c0, "R6 standby count", count, c0);
        chk(cap_fall == f0 && cap_rise == r0, "R6 standby rise cap", cap_rise, r0);
        mode = 3'd7;
        cap_in = 1'b0;
        step(30);
        chk(count == c0, "R6 module standby count", count, c0);
        chk(cap_fall == f0 && cap_rise == r0, "R6 module standby fall cap", cap_fall, f0);

        // R10: watch mode with a system tap ignores the capture input
        mode = 3'd3; clk_sel = 2'd2;
        cap_in = 1'b1;
        step(30);
        chk(cap_rise == r0, "R10 watch ignores rise", cap_rise, r0);
        chk(count == c0, "R10 watch count held", count, c0);
        cap_in = 1'b0;
        step(5);

        // R7: reset mode clears everything
        mode_reset();
        chk(count == 0 && cap_fall == 0 && cap_rise == 0, "R7 mode reset clears", count, 0);

        // R11: wrap and strobe
        mode = 3'd1; clk_sel = 2'd2;
        step(512);
        chk(count == 255 && ovf == 0, "R11 before wrap", count, 255);
        step(1);
        chk(count == 0, "R11 wrap to zero", count, 0);
        chk(ovf == 1, "R11 strobe high", ovf, 1);
        step(1);
        chk(ovf == 0, "R11 strobe one cycle", ovf, 0);

        // R1 R3 R4 R5 R6: sweep of mode, clock select and subclock select
        for (int m = 1; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int sb = 0; sb < 4; sb++) begin
                    int e, exp, lo, hi;
                    e = 300;
                    mode_reset();
                    mode = 3'(m); clk_sel = 2'(s); sub_sel = 2'(sb);
                    step(e);
                    if (!runs(m, s, sb)) begin
                        chk(count == 0, "R4 R5 R6 gated no count", count, 0);
                    end else if (s < 3) begin
                        exp = ((e - 1) / tap_period(s)) % 256;
                        chk(count == 8'(exp), "R1 tap count", count, exp);
                    end else begin
                        exp = e / (8 * WHALF);
                        lo = exp - 1; hi = exp + 1;
                        chk(int'(count) >= lo && int'(count) <= hi,
                            "R3 watch divide-by-4 count", count, exp);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule